// File: doc/BRIEF.md
# Shared-Memory Bitfield Write Engine

This engine lets a host change internal 24-bit registers through a table kept in shared memory, without any command channel. The host fills in a table of write descriptors, records where the table starts in a header word, and then sets a request flag in a second header word. The engine polls that flag. Once it finds the flag nonzero, it fetches each descriptor in turn. It inserts the requested bit field into the addressed register with a read-modify-write on the register-file port, and clears the flag when the last entry is done. The host knows the batch is complete when it sees the flag back at zero.

Every descriptor occupies six 16-bit words. The first word is a packed specification that gives the bit offset, the field width, the target kind and the top three address bits. The second word holds the low 16 address bits. Two 32-bit data words follow, each stored upper half first. The target kind is one of three: an X register, a Y register, or a long register that pairs the X and Y registers at the same address.

Both memory-side interfaces use valid/ready handshakes. A request stays valid and unchanged until ready is seen high at a clock edge. For each accepted read, the responder later returns exactly one response pulse. The engine keeps only one request in flight across both ports, and it always accepts a response when it arrives, so responses carry no back-pressure.

Top module: `smem_bitfield_writer`

## Requirements
- R1: While the flag word at address FLAG_ADDR reads zero, the engine issues no register-file request and writes nothing to shared memory.
- R2: After reading a nonzero flag, the engine handles min(entry_count, MAX_ENTRIES) entries and then writes 0 to FLAG_ADDR. That is the only shared-memory write it ever makes.
- R3: Entry i starts at word address VAR_BASE + T + 6*i, where T is the value read from OFS_ADDR. Word 0 is the specification, word 1 holds address bits 15..0, words 2 and 3 hold data word 1 (upper half, then lower half), and words 4 and 5 hold data word 2.
- R4: In the specification word, bits 15..11 are the offset, bits 10..6 are the width code, bits 5..3 are the kind, and bits 2..0 are target address bits 18..16. The register address presented is {spec[2:0], word1}.
- R5: A field write changes only register bits offset through offset+width-1, clipped at bit 23. Those bits take the low `width` bits of the data word's bits 23..0, and every other bit keeps its previous value.
- R6: Width code 0 means 24 bits. An entry with offset 0 and width code 0 writes the register without reading it first.
- R7: Kind 0 targets the Y register (rf_req_xsel=0) with data word 1. Kind 2 targets the X register (rf_req_xsel=1) with data word 1. Kind 1 writes the X register with data word 1 and then the Y register at the same address with data word 2, using the same field for both.
- R8: An entry whose width code is not one of 0, 1, 4, 8, 12, 16 or 20, whose kind is above 2, or whose offset is above 23 causes no register write. Each such entry adds one to err_count, which wraps.
- R9: With entry_count equal to 0, a set flag is cleared and no register is accessed. With entry_count above MAX_ENTRIES, only the first MAX_ENTRIES entries are applied.
- R10: A request held valid without ready keeps its address, write enable and data stable on the next cycle. A shared-memory request and a register-file request are never valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_count | input | CNT_W | Number of table entries to process per request |
| sm_req_valid | output | 1 | Shared-memory request valid |
| sm_req_ready | input | 1 | Shared-memory request accepted |
| sm_req_we | output | 1 | Shared-memory request is a write |
| sm_req_addr | output | SM_AW | Shared-memory word address |
| sm_req_wdata | output | 16 | Shared-memory write data |
| sm_rsp_valid | input | 1 | Shared-memory read data valid |
| sm_rsp_data | input | 16 | Shared-memory read data |
| rf_req_valid | output | 1 | Register-file request valid |
| rf_req_ready | input | 1 | Register-file request accepted |
| rf_req_we | output | 1 | Register-file request is a write |
| rf_req_xsel | output | 1 | 1 selects the X register, 0 the Y register |
| rf_req_addr | output | 19 | Register address |
| rf_req_wdata | output | 24 | Register write data |
| rf_rsp_valid | input | 1 | Register-file read data valid |
| rf_rsp_data | input | 24 | Register-file read data |
| err_count | output | ERR_W | Count of rejected entries |

## Verification
The bench builds the engine with an 8-bit shared-memory address, the flag at word 4, the offset at word 5, the table base at word 16, a 32-entry limit and an 8-bit error counter. With those values a 40-entry table still fits in memory, so the clamp at 32 can be observed. With 32 entries per batch, one batch can cover every 5-bit width code, and one batch per offset value covers all 32 offsets. In total the bench checks every combination of offset and width code, including the rejected ones, across all three valid kinds, plus one batch that walks the invalid kind codes. Both ready inputs toggle in fixed patterns, so back-pressure shows up on every kind of access.

// File: rtl/bfw_pkg.sv
package bfw_pkg;
  localparam int REG_W       = 24;
  localparam int TGT_AW      = 19;
  localparam int WORD_W      = 16;
  localparam int ENTRY_WORDS = 6;

  localparam logic [2:0] KIND_Y    = 3'd0;
  localparam logic [2:0] KIND_LONG = 3'd1;
  localparam logic [2:0] KIND_X    = 3'd2;

  typedef enum logic [2:0] {
    ST_POLL,
    ST_OFS,
    ST_FETCH,
    ST_CHECK,
    ST_RDREG,
    ST_WRREG,
    ST_CLEAR
  } eng_state_t;
endpackage

// File: rtl/bfw_spec_decode.sv
module bfw_spec_decode
  import bfw_pkg::*;
(
  input  logic [WORD_W-1:0] spec,
  output logic [REG_W-1:0]  mask,
  output logic [4:0]        shift,
  output logic [2:0]        kind,
  output logic              ok,
  output logic              full
);
  logic [4:0] off;
  logic [4:0] wcode;
  logic [5:0] wid;
  logic       wid_ok;

  assign off   = spec[15:11];
  assign wcode = spec[10:6];
  assign kind  = spec[5:3];
  assign shift = off;

  always_comb begin
    wid_ok = 1'b1;
    case (wcode)
      5'd0:                              wid = 6'(REG_W);
      5'd1, 5'd4, 5'd8, 5'd12, 5'd16, 5'd20: wid = {1'b0, wcode};
      default: begin
        wid    = '0;
        wid_ok = 1'b0;
      end
    endcase
  end

  for (genvar b = 0; b < REG_W; b++) begin : g_mask
    assign mask[b] = (b >= int'(off)) && (b < int'(off) + int'(wid));
  end

  assign ok   = wid_ok && (int'(off) < REG_W) && (kind <= KIND_X);
  assign full = &mask;
endmodule

// File: rtl/bfw_field_merge.sv
module bfw_field_merge #(
  parameter int W = 24
) (
  input  logic [W-1:0] old_val,
  input  logic [W-1:0] data,
  input  logic [W-1:0] mask,
  input  logic [4:0]   shift,
  output logic [W-1:0] merged
);
  logic [W-1:0] placed;

  assign placed = data << shift;
  assign merged = (placed & mask) | (old_val & ~mask);
endmodule

// File: rtl/smem_bitfield_writer.sv
module smem_bitfield_writer
  import bfw_pkg::*;
#(
  parameter int SM_AW       = 12,
  parameter int FLAG_ADDR   = 4,
  parameter int OFS_ADDR    = 5,
  parameter int VAR_BASE    = 16,
  parameter int MAX_ENTRIES = 32,
  parameter int CNT_W       = 6,
  parameter int ERR_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  entry_count,
  output logic              sm_req_valid,
  input  logic              sm_req_ready,
  output logic              sm_req_we,
  output logic [SM_AW-1:0]  sm_req_addr,
  output logic [15:0]       sm_req_wdata,
  input  logic              sm_rsp_valid,
  input  logic [15:0]       sm_rsp_data,
  output logic              rf_req_valid,
  input  logic              rf_req_ready,
  output logic              rf_req_we,
  output logic              rf_req_xsel,
  output logic [18:0]       rf_req_addr,
  output logic [23:0]       rf_req_wdata,
  input  logic              rf_rsp_valid,
  input  logic [23:0]       rf_rsp_data,
  output logic [ERR_W-1:0]  err_count
);
  localparam int IDX_W = $clog2(MAX_ENTRIES + 1);

  eng_state_t        st;
  logic              pend;
  logic              half;
  logic [SM_AW-1:0]  eptr;
  logic [IDX_W-1:0]  idx, lim, idx_nxt, cnt_lim;
  logic [2:0]        wsel;
  logic [WORD_W-1:0] words [ENTRY_WORDS];
  logic [REG_W-1:0]  old_q;
  logic [ERR_W-1:0]  err_q;

  logic [REG_W-1:0]  f_mask, f_data, f_new;
  logic [4:0]        f_shift;
  logic [2:0]        f_kind;
  logic              f_ok, f_full;
  logic              sm_acc, rf_acc, last_entry;

  bfw_spec_decode u_dec (
    .spec  (words[0]),
    .mask  (f_mask),
    .shift (f_shift),
    .kind  (f_kind),
    .ok    (f_ok),
    .full  (f_full)
  );

  assign f_data = half ? {words[4][7:0], words[5]} : {words[2][7:0], words[3]};

  bfw_field_merge #(.W(REG_W)) u_merge (
    .old_val (old_q),
    .data    (f_data),
    .mask    (f_mask),
    .shift   (f_shift),
    .merged  (f_new)
  );

  always_comb begin
    if (int'(entry_count) > MAX_ENTRIES) cnt_lim = IDX_W'(MAX_ENTRIES);
    else                                 cnt_lim = IDX_W'(entry_count);
  end

  assign idx_nxt    = idx + IDX_W'(1);
  assign last_entry = (idx_nxt == lim);

  // shared-memory request side
  always_comb begin
    sm_req_valid = !pend && (st == ST_POLL || st == ST_OFS ||
                             st == ST_FETCH || st == ST_CLEAR);
    sm_req_we    = (st == ST_CLEAR);
    sm_req_wdata = '0;
    case (st)
      ST_OFS:   sm_req_addr = SM_AW'(OFS_ADDR);
      ST_FETCH: sm_req_addr = eptr + SM_AW'(wsel);
      default:  sm_req_addr = SM_AW'(FLAG_ADDR);
    endcase
  end

  // register-file request side
  assign rf_req_valid = !pend && (st == ST_RDREG || st == ST_WRREG);
  assign rf_req_we    = (st == ST_WRREG);
  assign rf_req_xsel  = (f_kind == KIND_X) || (f_kind == KIND_LONG && !half);
  assign rf_req_addr  = {words[0][2:0], words[1]};
  assign rf_req_wdata = f_new;

  assign sm_acc    = sm_req_valid && sm_req_ready;
  assign rf_acc    = rf_req_valid && rf_req_ready;
  assign err_count = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_POLL;
      pend  <= 1'b0;
      half  <= 1'b0;
      eptr  <= '0;
      idx   <= '0;
      lim   <= '0;
      wsel  <= '0;
      old_q <= '0;
      err_q <= '0;
      for (int i = 0; i < ENTRY_WORDS; i++) words[i] <= '0;
    end else begin
      case (st)
        ST_POLL: begin
          if (pend) begin
            if (sm_rsp_valid) begin
              pend <= 1'b0;
              if (sm_rsp_data != '0) begin
                lim <= cnt_lim;
                st  <= (cnt_lim == '0) ? ST_CLEAR : ST_OFS;
              end
            end
          end else if (sm_acc) pend <= 1'b1;
        end
        ST_OFS: begin
          if (pend) begin
            if (sm_rsp_valid) begin
              pend <= 1'b0;
              eptr <= SM_AW'(VAR_BASE) + sm_rsp_data[SM_AW-1:0];
              idx  <= '0;
              wsel <= '0;
              st   <= ST_FETCH;
            end
          end else if (sm_acc) pend <= 1'b1;
        end
        ST_FETCH: begin
          if (pend) begin
            if (sm_rsp_valid) begin
              pend        <= 1'b0;
              words[wsel] <= sm_rsp_data;
              if (wsel == 3'(ENTRY_WORDS - 1)) begin
                wsel <= '0;
                st   <= ST_CHECK;
              end else wsel <= wsel + 3'd1;
            end
          end else if (sm_acc) pend <= 1'b1;
        end
        ST_CHECK: begin
          half <= 1'b0;
          if (!f_ok) begin
            err_q <= err_q + ERR_W'(1);
            if (last_entry) st <= ST_CLEAR;
            else begin
              idx  <= idx_nxt;
              eptr <= eptr + SM_AW'(ENTRY_WORDS);
              st   <= ST_FETCH;
            end
          end else st <= f_full ? ST_WRREG : ST_RDREG;
        end
        ST_RDREG: begin
          if (pend) begin
            if (rf_rsp_valid) begin
              pend  <= 1'b0;
              old_q <= rf_rsp_data;
              st    <= ST_WRREG;
            end
          end else if (rf_acc) pend <= 1'b1;
        end
        ST_WRREG: begin
          if (rf_acc) begin
            if (f_kind == KIND_LONG && !half) begin
              half <= 1'b1;
              st   <= f_full ? ST_WRREG : ST_RDREG;
            end else if (last_entry) st <= ST_CLEAR;
            else begin
              idx  <= idx_nxt;
              eptr <= eptr + SM_AW'(ENTRY_WORDS);
              st   <= ST_FETCH;
            end
          end
        end
        ST_CLEAR: begin
          if (sm_acc) st <= ST_POLL;
        end
        default: st <= ST_POLL;
      endcase
    end
  end
endmodule

// File: rtl/smem_bitfield_writer_chk.sv
module smem_bitfield_writer_chk #(
  parameter int SM_AW     = 12,
  parameter int FLAG_ADDR = 4,
  parameter int ERR_W     = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sm_req_valid,
  input logic             sm_req_ready,
  input logic             sm_req_we,
  input logic [SM_AW-1:0] sm_req_addr,
  input logic [15:0]      sm_req_wdata,
  input logic             rf_req_valid,
  input logic             rf_req_ready,
  input logic             rf_req_we,
  input logic             rf_req_xsel,
  input logic [18:0]      rf_req_addr,
  input logic [23:0]      rf_req_wdata,
  input logic [ERR_W-1:0] err_count
);
  // R10
  sm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sm_req_valid && !sm_req_ready |=> sm_req_valid && $stable(sm_req_addr) &&
    $stable(sm_req_we) && $stable(sm_req_wdata));

  // R10
  rf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_req_valid && !rf_req_ready |=> rf_req_valid && $stable(rf_req_addr) &&
    $stable(rf_req_we) && $stable(rf_req_xsel) && $stable(rf_req_wdata));

  // R10
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sm_req_valid && rf_req_valid));

  // R2
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sm_req_valid && sm_req_we |-> sm_req_addr == SM_AW'(FLAG_ADDR) && sm_req_wdata == '0);

  // R8
  err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_count != $past(err_count) |-> err_count == ERR_W'($past(err_count) + 1'b1));
endmodule

bind smem_bitfield_writer smem_bitfield_writer_chk #(
  .SM_AW(SM_AW), .FLAG_ADDR(FLAG_ADDR), .ERR_W(ERR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .sm_req_valid(sm_req_valid), .sm_req_ready(sm_req_ready), .sm_req_we(sm_req_we),
  .sm_req_addr(sm_req_addr), .sm_req_wdata(sm_req_wdata),
  .rf_req_valid(rf_req_valid), .rf_req_ready(rf_req_ready), .rf_req_we(rf_req_we),
  .rf_req_xsel(rf_req_xsel), .rf_req_addr(rf_req_addr), .rf_req_wdata(rf_req_wdata),
  .err_count(err_count)
);

// File: tb/smem_bitfield_writer_test.sv
`timescale 1ns/1ps
module smem_bitfield_writer_test;
  localparam int SM_AW = 8, FLAG_A = 4, OFS_A = 5, VBASE = 16, MAXE = 32, CNT_W = 6, ERR_W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [CNT_W-1:0] entry_count;
  logic sm_req_valid, sm_req_ready, sm_req_we, sm_rsp_valid;
  logic [SM_AW-1:0] sm_req_addr;
  logic [15:0] sm_req_wdata, sm_rsp_data;
  logic rf_req_valid, rf_req_ready, rf_req_we, rf_req_xsel, rf_rsp_valid;
  logic [18:0] rf_req_addr;
  logic [23:0] rf_req_wdata, rf_rsp_data;
  logic [ERR_W-1:0] err_count;

  smem_bitfield_writer #(
    .SM_AW(SM_AW), .FLAG_ADDR(FLAG_A), .OFS_ADDR(OFS_A), .VAR_BASE(VBASE),
    .MAX_ENTRIES(MAXE), .CNT_W(CNT_W), .ERR_W(ERR_W)
  ) uut (.*);

  logic [15:0] mem [256];
  logic [23:0] rfx [64];
  logic [23:0] rfy [64];
  logic [23:0] ex [64];
  logic [23:0] ey [64];
  logic [7:0]  tick;
  logic        host_we, rf_init;
  logic [7:0]  host_addr;
  logic [15:0] host_data;
  int          rf_seed;
  int          rd_cnt, wr_cnt, sm_wr_cnt;
  logic [18:0] last_addr;

  logic [15:0] e_spec [64];
  logic [15:0] e_lo   [64];
  logic [31:0] e_d1   [64];
  logic [31:0] e_d2   [64];

  int tests = 0, fails = 0, err_exp = 0;
  bit done = 0;

  assign sm_req_ready = (tick % 8'd3) != 8'd2;
  assign rf_req_ready = tick[1:0] != 2'd1;

  function automatic logic [23:0] h24(int i, int s);
    return 24'((i * 40503 + s * 2654435 + 7) ^ (i * s * 131) ^ (s << 9));
  endfunction

  function automatic logic [31:0] h32(int i, int s);
    return 32'((i * 69069 + s * 1103515 + 12345) ^ (i << 17) ^ (s * 977));
  endfunction

  function automatic bit ent_ok(int off, int wc, int kind);
    bit w = (wc == 0 || wc == 1 || wc == 4 || wc == 8 || wc == 12 || wc == 16 || wc == 20);
    return w && off < 24 && kind <= 2;
  endfunction

  function automatic logic [23:0] ins(logic [23:0] old, logic [31:0] d, int off, int wc);
    int w = (wc == 0) ? 24 : wc;
    logic [23:0] r = old;
    for (int b = 0; b < 24; b++)
      if (b >= off && b < off + w) r[b] = d[b - off];
    return r;
  endfunction

  // bench-side shared memory and register file responders
  always @(posedge clk) begin
    if (!rst_n) begin
      tick <= 0; sm_rsp_valid <= 0; rf_rsp_valid <= 0;
      sm_rsp_data <= 0; rf_rsp_data <= 0;
      rd_cnt <= 0; wr_cnt <= 0; sm_wr_cnt <= 0; last_addr <= 0;
      for (int i = 0; i < 256; i++) mem[i] <= 0;
      for (int i = 0; i < 64; i++) begin rfx[i] <= 0; rfy[i] <= 0; end
    end else begin
      tick <= tick + 8'd1;
      sm_rsp_valid <= 0;
      rf_rsp_valid <= 0;
      if (host_we) mem[host_addr] <= host_data;
      if (sm_req_valid && sm_req_ready) begin
        if (sm_req_we) begin mem[sm_req_addr] <= sm_req_wdata; sm_wr_cnt <= sm_wr_cnt + 1; end
        else begin sm_rsp_valid <= 1; sm_rsp_data <= mem[sm_req_addr]; end
      end
      if (rf_init)
        for (int i = 0; i < 64; i++) begin rfx[i] <= h24(i, rf_seed); rfy[i] <= h24(i + 64, rf_seed); end
      if (rf_req_valid && rf_req_ready) begin
        if (rf_req_we) begin
          wr_cnt <= wr_cnt + 1; last_addr <= rf_req_addr;
          if (rf_req_xsel) rfx[rf_req_addr[5:0]] <= rf_req_wdata;
          else             rfy[rf_req_addr[5:0]] <= rf_req_wdata;
        end else begin
          rd_cnt <= rd_cnt + 1; rf_rsp_valid <= 1;
          rf_rsp_data <= rf_req_xsel ? rfx[rf_req_addr[5:0]] : rfy[rf_req_addr[5:0]];
        end
      end
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hw(int a, logic [15:0] d);
    host_we = 1; host_addr = 8'(a); host_data = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic init_rf(int seed);
    rf_seed = seed; rf_init = 1;
    @(negedge clk);
    rf_init = 0;
    for (int i = 0; i < 64; i++) begin ex[i] = h24(i, seed); ey[i] = h24(i + 64, seed); end
  endtask

  task automatic model(int cnt);
    int lim = (cnt > MAXE) ? MAXE : cnt;
    for (int i = 0; i < lim; i++) begin
      int off = int'(e_spec[i][15:11]);
      int wc  = int'(e_spec[i][10:6]);
      int k   = int'(e_spec[i][5:3]);
      int a   = int'(e_lo[i][5:0]);
      if (!ent_ok(off, wc, k)) err_exp++;
      else if (k == 0) ey[a] = ins(ey[a], e_d1[i], off, wc);
      else if (k == 2) ex[a] = ins(ex[a], e_d1[i], off, wc);
      else begin
        ex[a] = ins(ex[a], e_d1[i], off, wc);
        ey[a] = ins(ey[a], e_d2[i], off, wc);
      end
    end
  endtask

  task automatic run(int tofs, int n, int cnt);
    int guard = 0;
    for (int i = 0; i < n; i++) begin
      int b = VBASE + tofs + 6 * i;
      hw(b, e_spec[i]); hw(b + 1, e_lo[i]);
      hw(b + 2, e_d1[i][31:16]); hw(b + 3, e_d1[i][15:0]);
      hw(b + 4, e_d2[i][31:16]); hw(b + 5, e_d2[i][15:0]);
    end
    hw(OFS_A, 16'(tofs));
    entry_count = CNT_W'(cnt);
    hw(FLAG_A, 16'h0001);
    while (mem[FLAG_A] != 0 && guard < 40000) begin @(negedge clk); guard++; end
    check(guard < 40000, "R2", "flag cleared", longint'(mem[FLAG_A]), 0);
    repeat (3) @(negedge clk);
    model(cnt);
  endtask

  task automatic cmp_rf(string req);
    for (int i = 0; i < 64; i++) begin
      check(rfx[i] == ex[i], req, $sformatf("X[%0d]", i), rfx[i], ex[i]);
      check(rfy[i] == ey[i], req, $sformatf("Y[%0d]", i), rfy[i], ey[i]);
    end
    check(err_count == ERR_W'(err_exp), "R8", "err_count", err_count, ERR_W'(err_exp));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int r0, w0;
    rst_n = 0; host_we = 0; rf_init = 0; host_addr = 0; host_data = 0; rf_seed = 0;
    entry_count = CNT_W'(MAXE);
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(err_count == 0, "R8", "reset err_count", err_count, 0);
    check(rf_req_valid == 0, "R1", "reset rf_req_valid", rf_req_valid, 0);

    // R1: flag clear leaves everything untouched
    repeat (300) @(negedge clk);
    check(rd_cnt + wr_cnt == 0, "R1", "rf accesses while idle", rd_cnt + wr_cnt, 0);
    check(sm_wr_cnt == 0, "R1", "memory writes while idle", sm_wr_cnt, 0);

    // R3 R4 R5 R6 R7 R8: every offset 0..31 against every width code 0..31
    for (int o = 0; o < 32; o++) begin
      init_rf(o + 1);
      for (int i = 0; i < 32; i++) begin
        e_spec[i] = {5'(o), 5'(i), 3'(i % 3), 3'b000};
        e_lo[i] = 16'(i); e_d1[i] = h32(i, o); e_d2[i] = h32(i + 99, o);
      end
      run(o % 4, 32, 32);
      cmp_rf("R5");
    end

    // R7 R8: invalid kind codes 3..7 rejected, valid ones applied
    init_rf(77);
    for (int i = 0; i < 32; i++) begin
      e_spec[i] = {5'd4, 5'd8, 3'(i % 8), 3'b000};
      e_lo[i] = 16'(i); e_d1[i] = h32(i, 77); e_d2[i] = h32(i, 78);
    end
    run(2, 32, 32);
    cmp_rf("R7");

    // R6: full-width Y write needs no read
    init_rf(5);
    r0 = rd_cnt; w0 = wr_cnt;
    e_spec[0] = {5'd0, 5'd0, 3'd0, 3'b000}; e_lo[0] = 16'd9; e_d1[0] = 32'hFF12_3456; e_d2[0] = 0;
    run(0, 1, 1);
    check(rd_cnt - r0 == 0, "R6", "reads on full width", rd_cnt - r0, 0);
    check(wr_cnt - w0 == 1, "R6", "writes on full width", wr_cnt - w0, 1);
    check(rfy[9] == 24'h123456, "R6", "Y[9]", rfy[9], 24'h123456);

    // R7: long full-width writes two halves, no reads
    r0 = rd_cnt; w0 = wr_cnt;
    e_spec[0] = {5'd0, 5'd0, 3'd1, 3'b000}; e_lo[0] = 16'd11; e_d1[0] = 32'h00AB_CDEF; e_d2[0] = 32'h0013_5799;
    run(0, 1, 1);
    check(rd_cnt - r0 == 0 && wr_cnt - w0 == 2, "R7", "long access counts", (rd_cnt - r0) * 16 + wr_cnt - w0, 2);
    cmp_rf("R7");

    // R4: upper address bits come from spec[2:0]
    e_spec[0] = {5'd3, 5'd4, 3'd2, 3'b101}; e_lo[0] = 16'h0007; e_d1[0] = 32'h0000_000A; e_d2[0] = 0;
    run(1, 1, 1);
    check(last_addr == 19'h50007, "R4", "target address", last_addr, 19'h50007);
    cmp_rf("R4");

    // R9: zero count clears flag without accesses
    r0 = rd_cnt; w0 = wr_cnt;
    run(0, 0, 0);
    check(rd_cnt + wr_cnt - r0 - w0 == 0, "R9", "accesses with zero count", rd_cnt + wr_cnt - r0 - w0, 0);

    // R9: count above the limit stops after 32 entries
    init_rf(9);
    w0 = wr_cnt;
    for (int i = 0; i < 40; i++) begin
      e_spec[i] = {5'd0, 5'd0, 3'd0, 3'b000}; e_lo[i] = 16'(i); e_d1[i] = h32(i, 9); e_d2[i] = 0;
    end
    run(0, 40, 40);
    check(wr_cnt - w0 == 32, "R9", "writes with count 40", wr_cnt - w0, 32);
    cmp_rf("R9");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule